// File: doc/BRIEF.md
# DRAM Bring-up Sequencer

This block walks a DRAM controller from reset to a ready state, one step at a time and always in the same order. After a start pulse it pulses the external memory reset and brings up the master DLL in three timed phases, with the memory clock output held off. It then writes the device configuration, turns the clock output back on, fires the controller initialization trigger and waits for that trigger to clear. Next it brings up the slave DLLs in the same three phases and loads the mode registers. When resuming from standby it releases the pad hold and issues a self-refresh exit. Every run then ends with a refresh command.

Each wait on a busy flag from the controller model has a timeout. The timeout is counted in microseconds, derived from the clock by a parameter. If a busy flag is still high when the timeout runs out, the sequencer stops and raises a sticky error. The bus-width input picks how many slave DLLs take part. Commands go out as 5-bit codes with a one-cycle valid strobe.

Top module: `dram_bringup_seq`

## Requirements
- R1: After reset: mem_rst_o=1, clk_out_en_o=0, master DLL held (disable=1, not-reset=0), all slave DLLs held, and no strobe, done_o or err_o active.
- R2: In the cycle after start_i is sampled in idle, mem_rst_o goes low. It stays low for exactly SETTLE_CYC cycles and then returns high.
- R3: The master DLL phases are: held (disable=1, not-reset=0) from the cycle mem_rst_o rises; both low SETTLE_CYC cycles later; running (disable=0, not-reset=1) another SETTLE_CYC cycles later. Disable and not-reset are never high together.
- R4: clk_out_en_o is low from the start through the master DLL phases. The one-cycle cfg_wr_o strobe comes SETTLE_CYC cycles after the master DLL starts running, and clk_out_en_o rises in the following cycle.
- R5: init_go_o pulses for one cycle, in the same cycle that clk_out_en_o rises. The slave DLL phases begin only in the cycle after init_busy_i is first seen low.
- R6: With bus32_i=1 at start, slave bits [3:0] take part. With bus32_i=0, only bits [1:0] take part, and bits [3:2] stay held (disable=1, not-reset=0).
- R7: All participating slave DLLs change together. Each of their three phases (held, both low, running) lasts SETTLE_CYC cycles.
- R8: mode_ld_o pulses for one cycle when the slave DLLs have been running for SETTLE_CYC cycles.
- R9: With resume_i=1 at start, pad_rel_o pulses in the cycle after mode_ld_o. The self-refresh exit command (code 0x12) is issued in the cycle after hold_busy_i is first seen low. With resume_i=0, neither happens.
- R10: The refresh command (code 0x13) is always issued exactly once. It comes in the cycle after the self-refresh exit's cmd_busy_i is seen low, or in the cycle after mode_ld_o when there is no resume.
- R11: done_o pulses high for one cycle, in the cycle after cmd_busy_i for the refresh is first seen low.
- R12: If a busy flag stays high for TIMEOUT_US×CLKS_PER_US cycles of a wait, err_o rises one cycle later. It then stays high, with no further commands and no done_o, until the next start_i; err_o clears in the cycle after that start.
- R13: A busy flag that clears in the very cycle the timeout is reached still lets the sequence continue, without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a bring-up run from idle or from the error state |
| bus32_i | input | 1 | 1 selects the wide data bus (all slave DLLs), 0 the narrow bus |
| resume_i | input | 1 | Resume-from-standby: adds pad-hold release and self-refresh exit |
| init_busy_i | input | 1 | Controller initialization still running |
| hold_busy_i | input | 1 | Pad hold still in force |
| cmd_busy_i | input | 1 | Command still executing |
| mem_rst_o | output | 1 | External memory reset control level |
| clk_out_en_o | output | 1 | Memory clock output enable |
| mdll_dis_o | output | 1 | Master DLL disable |
| mdll_nrst_o | output | 1 | Master DLL not-reset |
| sdll_dis_o | output | NSLV_WIDE (4) | Slave DLL disables, bit 0 = first slave |
| sdll_nrst_o | output | NSLV_WIDE (4) | Slave DLL not-resets |
| cfg_wr_o | output | 1 | One-cycle device configuration write strobe |
| init_go_o | output | 1 | One-cycle initialization trigger |
| mode_ld_o | output | 1 | One-cycle mode-register load strobe |
| pad_rel_o | output | 1 | One-cycle pad-hold release strobe |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | 5 | Command code: 0x12 self-refresh exit, 0x13 refresh |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky timeout error |

## Verification
Every result is predicted from an anchor cycle. The anchors are the cycle the start is sampled, the cycle mem_rst_o falls, and the first cycle each modelled busy flag reads low. Level changes follow their anchor after whole multiples of SETTLE_CYC. Strobes follow one cycle after the condition that releases them, and err_o follows TIMEOUT_US×CLKS_PER_US+1 cycles after the wait begins. The bench logs, once per cycle on the falling edge, the exact cycle of each edge and strobe along with the cycle each busy flag drops. It compares those numbers to the predicted ones, so a result that is one cycle early or late fails.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

   typedef enum logic [4:0] {
      ST_IDLE,
      ST_RST_LO,
      ST_MD_P1,
      ST_MD_P2,
      ST_MD_P3,
      ST_CFG,
      ST_INIT_GO,
      ST_INIT_WAIT,
      ST_SD_P1,
      ST_SD_P2,
      ST_SD_P3,
      ST_MODE,
      ST_HOLD_REL,
      ST_HOLD_WAIT,
      ST_SRX_GO,
      ST_SRX_WAIT,
      ST_REF_GO,
      ST_REF_WAIT,
      ST_DONE,
      ST_FAIL
   } seq_state_e;

   localparam logic [4:0] CMD_SR_EXIT = 5'h12;
   localparam logic [4:0] CMD_REFRESH = 5'h13;

   typedef struct packed {
      logic dis;
      logic nrst;
   } dll_lvl_t;

   localparam dll_lvl_t DLL_HELD    = '{dis: 1'b1, nrst: 1'b0};
   localparam dll_lvl_t DLL_ALL_LOW = '{dis: 1'b0, nrst: 1'b0};
   localparam dll_lvl_t DLL_RUN     = '{dis: 1'b0, nrst: 1'b1};

endpackage

// File: rtl/bringup_settle.sv
module bringup_settle #(
   parameter int SETTLE_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic last_o
);
   localparam int SW = $clog2(SETTLE_CYC);

   if (SETTLE_CYC < 16) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 16");
   end

   logic [SW-1:0] cnt_q;

   assign last_o = run_i && (cnt_q == SW'(SETTLE_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (run_i && !last_o)
         cnt_q <= cnt_q + 1'b1;
      else
         cnt_q <= '0;
   end

   AST_SETTLE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_i) |-> (cnt_q == '0)); // R3

endmodule

// File: rtl/bringup_wait_timer.sv
module bringup_wait_timer #(
   parameter int CLKS_PER_US = 250,
   parameter int TIMEOUT_US  = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);
   localparam int CW = $clog2(CLKS_PER_US);
   localparam int UW = $clog2(TIMEOUT_US + 1);

   if (CLKS_PER_US < 2) begin : g_bad_tick
      $error("CLKS_PER_US must be at least 2");
   end
   if (TIMEOUT_US < 1) begin : g_bad_tmo
      $error("TIMEOUT_US must be at least 1");
   end

   logic [CW-1:0] sub_q;
   logic [UW-1:0] us_q;

   assign expire_o = (us_q == UW'(TIMEOUT_US));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         us_q  <= '0;
      end else if (!run_i) begin
         sub_q <= '0;
         us_q  <= '0;
      end else if (!expire_o) begin
         if (sub_q == CW'(CLKS_PER_US - 1)) begin
            sub_q <= '0;
            us_q  <= us_q + 1'b1;
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end
   end

   AST_EXPIRE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> $past(run_i)); // R12

endmodule

// File: rtl/bringup_slave_dll.sv
module bringup_slave_dll import bringup_pkg::*; #(
   parameter int NSLV_WIDE   = 4,
   parameter int NSLV_NARROW = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wide_i,
   input  logic                 clr_i,
   input  logic                 set_i,
   input  dll_lvl_t             lvl_i,
   output logic [NSLV_WIDE-1:0] dis_o,
   output logic [NSLV_WIDE-1:0] nrst_o
);
   if (NSLV_NARROW < 1 || NSLV_NARROW > NSLV_WIDE) begin : g_bad_count
      $error("NSLV_NARROW must lie in 1..NSLV_WIDE");
   end

   for (genvar g = 0; g < NSLV_WIDE; g++) begin : g_slv
      logic en;
      logic dis_q;
      logic nrst_q;

      if (g < NSLV_NARROW) begin : g_base
         assign en = 1'b1;
      end else begin : g_ext
         assign en = wide_i;
         AST_IDLE_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
            !wide_i |-> (dis_q && !nrst_q)); // R6
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dis_q  <= DLL_HELD.dis;
            nrst_q <= DLL_HELD.nrst;
         end else if (clr_i) begin
            dis_q  <= DLL_HELD.dis;
            nrst_q <= DLL_HELD.nrst;
         end else if (set_i && en) begin
            dis_q  <= lvl_i.dis;
            nrst_q <= lvl_i.nrst;
         end
      end

      assign dis_o[g]  = dis_q;
      assign nrst_o[g] = nrst_q;
   end

endmodule

// File: rtl/dram_bringup_seq.sv
module dram_bringup_seq import bringup_pkg::*; #(
   parameter int SETTLE_CYC  = 16,
   parameter int CLKS_PER_US = 250,
   parameter int TIMEOUT_US  = 1000000,
   parameter int NSLV_WIDE   = 4,
   parameter int NSLV_NARROW = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 bus32_i,
   input  logic                 resume_i,
   input  logic                 init_busy_i,
   input  logic                 hold_busy_i,
   input  logic                 cmd_busy_i,
   output logic                 mem_rst_o,
   output logic                 clk_out_en_o,
   output logic                 mdll_dis_o,
   output logic                 mdll_nrst_o,
   output logic [NSLV_WIDE-1:0] sdll_dis_o,
   output logic [NSLV_WIDE-1:0] sdll_nrst_o,
   output logic                 cfg_wr_o,
   output logic                 init_go_o,
   output logic                 mode_ld_o,
   output logic                 pad_rel_o,
   output logic                 cmd_valid_o,
   output logic [4:0]           cmd_code_o,
   output logic                 done_o,
   output logic                 err_o
);
   seq_state_e state_q, state_d;
   logic       settle_run, settle_last;
   logic       wait_run, wait_busy, wait_expire;
   logic       enter;
   logic       mem_rst_q, clk_en_q, err_q, bus32_q, resume_q;
   dll_lvl_t   mdll_q;
   logic       slv_clr, slv_set;
   dll_lvl_t   slv_lvl;

   assign settle_run = state_q inside {ST_RST_LO, ST_MD_P1, ST_MD_P2, ST_MD_P3,
                                       ST_SD_P1, ST_SD_P2, ST_SD_P3};
   assign wait_run   = state_q inside {ST_INIT_WAIT, ST_HOLD_WAIT, ST_SRX_WAIT, ST_REF_WAIT};
   assign wait_busy  = (state_q == ST_INIT_WAIT) ? init_busy_i :
                       (state_q == ST_HOLD_WAIT) ? hold_busy_i : cmd_busy_i;

   bringup_settle #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (settle_run),
      .last_o (settle_last)
   );

   bringup_wait_timer #(.CLKS_PER_US(CLKS_PER_US), .TIMEOUT_US(TIMEOUT_US)) i_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (wait_run),
      .expire_o (wait_expire)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE, ST_FAIL: if (start_i) state_d = ST_RST_LO;
         ST_RST_LO:    if (settle_last) state_d = ST_MD_P1;
         ST_MD_P1:     if (settle_last) state_d = ST_MD_P2;
         ST_MD_P2:     if (settle_last) state_d = ST_MD_P3;
         ST_MD_P3:     if (settle_last) state_d = ST_CFG;
         ST_CFG:       state_d = ST_INIT_GO;
         ST_INIT_GO:   state_d = ST_INIT_WAIT;
         ST_INIT_WAIT: if (!wait_busy) state_d = ST_SD_P1;
                       else if (wait_expire) state_d = ST_FAIL;
         ST_SD_P1:     if (settle_last) state_d = ST_SD_P2;
         ST_SD_P2:     if (settle_last) state_d = ST_SD_P3;
         ST_SD_P3:     if (settle_last) state_d = ST_MODE;
         ST_MODE:      state_d = resume_q ? ST_HOLD_REL : ST_REF_GO;
         ST_HOLD_REL:  state_d = ST_HOLD_WAIT;
         ST_HOLD_WAIT: if (!wait_busy) state_d = ST_SRX_GO;
                       else if (wait_expire) state_d = ST_FAIL;
         ST_SRX_GO:    state_d = ST_SRX_WAIT;
         ST_SRX_WAIT:  if (!wait_busy) state_d = ST_REF_GO;
                       else if (wait_expire) state_d = ST_FAIL;
         ST_REF_GO:    state_d = ST_REF_WAIT;
         ST_REF_WAIT:  if (!wait_busy) state_d = ST_DONE;
                       else if (wait_expire) state_d = ST_FAIL;
         ST_DONE:      state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   assign enter = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         mem_rst_q <= 1'b1;
         clk_en_q  <= 1'b0;
         err_q     <= 1'b0;
         bus32_q   <= 1'b0;
         resume_q  <= 1'b0;
         mdll_q    <= DLL_HELD;
      end else begin
         state_q <= state_d;
         if (enter) begin
            case (state_d)
               ST_RST_LO: begin
                  mem_rst_q <= 1'b0;
                  clk_en_q  <= 1'b0;
                  err_q     <= 1'b0;
                  mdll_q    <= DLL_HELD;
                  bus32_q   <= bus32_i;
                  resume_q  <= resume_i;
               end
               ST_MD_P1:   mem_rst_q <= 1'b1;
               ST_MD_P2:   mdll_q    <= DLL_ALL_LOW;
               ST_MD_P3:   mdll_q    <= DLL_RUN;
               ST_INIT_GO: clk_en_q  <= 1'b1;
               ST_FAIL:    err_q     <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign slv_clr = enter && (state_d == ST_RST_LO);
   assign slv_set = enter && (state_d == ST_SD_P2 || state_d == ST_SD_P3);
   assign slv_lvl = (state_d == ST_SD_P3) ? DLL_RUN : DLL_ALL_LOW;

   bringup_slave_dll #(.NSLV_WIDE(NSLV_WIDE), .NSLV_NARROW(NSLV_NARROW)) i_slaves (
      .clk    (clk),
      .rst_n  (rst_n),
      .wide_i (bus32_q),
      .clr_i  (slv_clr),
      .set_i  (slv_set),
      .lvl_i  (slv_lvl),
      .dis_o  (sdll_dis_o),
      .nrst_o (sdll_nrst_o)
   );

   assign mem_rst_o    = mem_rst_q;
   assign clk_out_en_o = clk_en_q;
   assign mdll_dis_o   = mdll_q.dis;
   assign mdll_nrst_o  = mdll_q.nrst;
   assign cfg_wr_o     = (state_q == ST_CFG);
   assign init_go_o    = (state_q == ST_INIT_GO);
   assign mode_ld_o    = (state_q == ST_MODE);
   assign pad_rel_o    = (state_q == ST_HOLD_REL);
   assign cmd_valid_o  = (state_q == ST_SRX_GO) || (state_q == ST_REF_GO);
   assign cmd_code_o   = (state_q == ST_SRX_GO) ? CMD_SR_EXIT :
                         (state_q == ST_REF_GO) ? CMD_REFRESH : 5'h00;
   assign done_o       = (state_q == ST_DONE);
   assign err_o        = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> err_o); // R12
   AST_NO_CMD_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!cmd_valid_o && !done_o)); // R12
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R11
   AST_MDLL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mdll_dis_o && mdll_nrst_o)); // R3
   AST_CLK_OFF_IN_DLL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_MD_P2) |-> !clk_out_en_o); // R4
   AST_SLAVE_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SD_P1 && $past(state_q) == ST_INIT_WAIT) |-> !$past(init_busy_i)); // R5
   AST_SRX_NEEDS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_code_o == CMD_SR_EXIT) |-> resume_q); // R9

endmodule

// File: tb/test_dram_bringup_seq.sv
module test_dram_bringup_seq;
   localparam int S    = 16;
   localparam int CPU  = 4;
   localparam int TMO  = 5;
   localparam int N    = CPU * TMO;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, bus32_i = 1'b0, resume_i = 1'b0;
   logic init_busy = 1'b0, hold_busy = 1'b0, cmd_busy = 1'b0;
   logic mem_rst_o, clk_out_en_o, mdll_dis_o, mdll_nrst_o;
   logic [3:0] sdll_dis_o, sdll_nrst_o;
   logic cfg_wr_o, init_go_o, mode_ld_o, pad_rel_o, cmd_valid_o, done_o, err_o;
   logic [4:0] cmd_code_o;

   always #2 clk = ~clk;

   dram_bringup_seq #(.SETTLE_CYC(S), .CLKS_PER_US(CPU), .TIMEOUT_US(TMO),
                      .NSLV_WIDE(4), .NSLV_NARROW(2)) i_dram_bringup_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus32_i(bus32_i), .resume_i(resume_i),
      .init_busy_i(init_busy), .hold_busy_i(hold_busy), .cmd_busy_i(cmd_busy),
      .mem_rst_o(mem_rst_o), .clk_out_en_o(clk_out_en_o), .mdll_dis_o(mdll_dis_o),
      .mdll_nrst_o(mdll_nrst_o), .sdll_dis_o(sdll_dis_o), .sdll_nrst_o(sdll_nrst_o),
      .cfg_wr_o(cfg_wr_o), .init_go_o(init_go_o), .mode_ld_o(mode_ld_o), .pad_rel_o(pad_rel_o),
      .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o), .done_o(done_o), .err_o(err_o));

   int n_tests = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;
   // event log
   int t_rst_fall, t_rst_rise, t_mdis_fall, t_mnrst_rise, t_clk_rise, t_clk_fall;
   int t_cfg, t_igo, t_ifree, t_sdis_fall, t_snrst_rise, t_mode, t_prel, t_hfree;
   int t_srx, t_xfree, t_ref, t_rfree, t_done, t_err, t_err_fall;
   int n_cmd, n_prel, n_done, n_both, n_skew, n_unused, n_badcode;
   logic [4:0] last_code = 5'h00;
   logic p_rst = 1'b1, p_mdis = 1'b1, p_mnrst = 1'b0, p_clk = 1'b0;
   logic p_sdis = 1'b1, p_snrst = 1'b0, p_err = 1'b0;
   logic [3:0] m;
   // controller model
   int icnt = 0, hcnt = 0, ccnt = 0, ilat = 1, hlat = 1, clat = 1;
   bit cstuck = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clr_ev();
      t_rst_fall = -1; t_rst_rise = -1; t_mdis_fall = -1; t_mnrst_rise = -1;
      t_clk_rise = -1; t_clk_fall = -1; t_cfg = -1; t_igo = -1; t_ifree = -1;
      t_sdis_fall = -1; t_snrst_rise = -1; t_mode = -1; t_prel = -1; t_hfree = -1;
      t_srx = -1; t_xfree = -1; t_ref = -1; t_rfree = -1; t_done = -1; t_err = -1;
      t_err_fall = -1;
      n_cmd = 0; n_prel = 0; n_done = 0; n_both = 0; n_skew = 0; n_unused = 0; n_badcode = 0;
   endtask

   // monitor and controller model, both on the falling edge
   initial begin
      clr_ev();
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (p_rst && !mem_rst_o)      t_rst_fall   = cyc;
            if (!p_rst && mem_rst_o)      t_rst_rise   = cyc;
            if (p_mdis && !mdll_dis_o)    t_mdis_fall  = cyc;
            if (!p_mnrst && mdll_nrst_o)  t_mnrst_rise = cyc;
            if (!p_clk && clk_out_en_o)   t_clk_rise   = cyc;
            if (p_clk && !clk_out_en_o)   t_clk_fall   = cyc;
            if (p_sdis && !sdll_dis_o[0]) t_sdis_fall  = cyc;
            if (!p_snrst && sdll_nrst_o[0]) t_snrst_rise = cyc;
            if (!p_err && err_o)          t_err        = cyc;
            if (p_err && !err_o)          t_err_fall   = cyc;
            if (cfg_wr_o)  t_cfg  = cyc;
            if (init_go_o) t_igo  = cyc;
            if (mode_ld_o) t_mode = cyc;
            if (pad_rel_o) begin t_prel = cyc; n_prel++; end
            if (done_o)    begin t_done = cyc; n_done++; end
            if (cmd_valid_o) begin
               n_cmd++;
               last_code = cmd_code_o;
               if (cmd_code_o == 5'h12)      t_srx = cyc;
               else if (cmd_code_o == 5'h13) t_ref = cyc;
               else                          n_badcode++;
            end
            if (mdll_dis_o && mdll_nrst_o) n_both++;
            if (t_rst_fall >= 0) begin
               m = bus32_i ? 4'hF : 4'h3;
               if ((((sdll_dis_o ^ {4{sdll_dis_o[0]}}) & m) != 4'h0) ||
                   (((sdll_nrst_o ^ {4{sdll_nrst_o[0]}}) & m) != 4'h0)) n_skew++;
               if (((sdll_dis_o & ~m) != ~m) || ((sdll_nrst_o & ~m) != 4'h0)) n_unused++;
            end
            p_rst = mem_rst_o; p_mdis = mdll_dis_o; p_mnrst = mdll_nrst_o; p_clk = clk_out_en_o;
            p_sdis = sdll_dis_o[0]; p_snrst = sdll_nrst_o[0]; p_err = err_o;
         end
         if (init_go_o) icnt = ilat; else if (icnt > 0) icnt--;
         if (pad_rel_o) hcnt = hlat; else if (hcnt > 0) hcnt--;
         if (cmd_valid_o) ccnt = clat; else if (ccnt > 0 && !cstuck) ccnt--;
         if (init_busy && icnt == 0) t_ifree = cyc;
         if (hold_busy && hcnt == 0) t_hfree = cyc;
         if (cmd_busy && ccnt == 0) begin
            if (last_code == 5'h12) t_xfree = cyc; else t_rfree = cyc;
         end
         init_busy = (icnt != 0);
         hold_busy = (hcnt != 0);
         cmd_busy  = (ccnt != 0);
      end
   end

   task automatic launch(input bit wide, input bit res, output int t0);
      clr_ev();
      @(negedge clk); #1;
      bus32_i = wide; resume_i = res; start_i = 1'b1; t0 = cyc;
      @(negedge clk); #1;
      start_i = 1'b0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 3000 && !(done_o || err_o); i++) @(negedge clk);
      repeat (3) @(negedge clk);
      #1;
   endtask

   task automatic check_front(input int t0);
      int a;
      a = t0 + 1;
      chk("R2 reset low after start", t_rst_fall, a);
      chk("R2 reset release", t_rst_rise, a + S);
      chk("R3 master both low", t_mdis_fall, a + 2*S);
      chk("R3 master running", t_mnrst_rise, a + 3*S);
      chk("R3 never both high", n_both, 0);
      chk("R4 config strobe", t_cfg, a + 4*S);
      chk("R4 clock output on", t_clk_rise, a + 4*S + 1);
      chk("R5 init trigger", t_igo, a + 4*S + 1);
      chk("R5 slave start after init clear", t_sdis_fall, t_ifree + 1 + S);
      chk("R7 slave running", t_snrst_rise, t_ifree + 1 + 2*S);
      chk("R7 slaves move together", n_skew, 0);
      chk("R8 mode load", t_mode, t_ifree + 1 + 3*S);
   endtask

   task automatic t_reset_state();
      chk("R1 mem_rst", mem_rst_o, 1);
      chk("R1 clk_out_en", clk_out_en_o, 0);
      chk("R1 master dis", mdll_dis_o, 1);
      chk("R1 master nrst", mdll_nrst_o, 0);
      chk("R1 slave dis", sdll_dis_o, 4'hF);
      chk("R1 slave nrst", sdll_nrst_o, 4'h0);
      chk("R1 strobes", {cfg_wr_o, init_go_o, mode_ld_o, pad_rel_o, cmd_valid_o}, 0);
      chk("R1 done/err", {done_o, err_o}, 0);
   endtask

   task automatic t_wide_cold();
      int t0;
      ilat = 3; clat = 2; hlat = 1; cstuck = 1'b0;
      launch(1'b1, 1'b0, t0);
      wait_end();
      check_front(t0);
      chk("R6 wide slaves running", sdll_nrst_o, 4'hF);
      chk("R9 no pad release", n_prel, 0);
      chk("R10 one command", n_cmd, 1);
      chk("R10 refresh after mode", t_ref, t_mode + 1);
      chk("R10 legal codes", n_badcode, 0);
      chk("R11 done timing", t_done, t_rfree + 1);
      chk("R11 single done", n_done, 1);
      chk("R12 no error", err_o, 0);
   endtask

   task automatic t_narrow_resume();
      int t0;
      ilat = 5; hlat = 4; clat = 3; cstuck = 1'b0;
      launch(1'b0, 1'b1, t0);
      wait_end();
      check_front(t0);
      chk("R4 clock output off at start", t_clk_fall, t0 + 1);
      chk("R6 narrow slaves running", sdll_nrst_o, 4'h3);
      chk("R6 unused slaves held", n_unused, 0);
      chk("R9 pad release", t_prel, t_mode + 1);
      chk("R9 self-refresh exit", t_srx, t_hfree + 1);
      chk("R10 refresh after exit", t_ref, t_xfree + 1);
      chk("R10 two commands", n_cmd, 2);
      chk("R11 done timing", t_done, t_rfree + 1);
   endtask

   task automatic t_timeout_edge();
      int t0;
      ilat = N + 1; clat = 1; cstuck = 1'b0;
      launch(1'b1, 1'b0, t0);
      wait_end();
      chk("R13 no error at boundary", err_o, 0);
      chk("R13 init freed at limit", t_ifree, t_igo + N + 1);
      chk("R13 slaves proceed", t_sdis_fall, t_ifree + 1 + S);
      chk("R13 done", n_done, 1);
   endtask

   task automatic t_timeout_fail();
      int t0, ncmd;
      ilat = 2; clat = 4; cstuck = 1'b1;
      launch(1'b1, 1'b0, t0);
      wait_end();
      chk("R12 error timing", t_err, t_ref + N + 2);
      chk("R12 no done", n_done, 0);
      ncmd = n_cmd;
      cstuck = 1'b0;
      repeat (30) @(negedge clk);
      #1;
      chk("R12 error sticky", err_o, 1);
      chk("R12 no further commands", n_cmd, ncmd);
      chk("R12 still no done", n_done, 0);
   endtask

   task automatic t_restart();
      int t0;
      ilat = 2; clat = 2; cstuck = 1'b0;
      launch(1'b1, 1'b0, t0);
      wait_end();
      chk("R12 error cleared by start", t_err_fall, t0 + 1);
      chk("R12 restart completes", n_done, 1);
      chk("R12 restart error low", err_o, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      #1;
      t_reset_state();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      t_reset_state();
      t_wide_cold();
      t_narrow_resume();
      t_timeout_edge();
      t_timeout_fail();
      t_restart();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule